// File: doc/BRIEF.md
# Per-Index Event Message Counter

This block counts event messages that arrive on an ingress lane. Every message carries a global event index, and each index inside a configured window selects one counter in an array. A counter that leaves zero makes the block emit a count-up event on the egress lane. A counter that software brings back to zero makes it emit a count-down event. Software acknowledges messages by writing an amount that is subtracted from a chosen counter.

Each counter has its own mapping register, which holds the global index that goes out with that counter's egress events. The egress lane can be wired back to the ingress lane, so the block's own events count like any other message. A small egress queue absorbs events while the egress lane is stalled. The ingress and acknowledge handshakes hold off when the queue cannot take the events that an accepted transaction could produce.

Top module: `evt_msg_counter`

## Requirements
- R1: After reset every counter reads 0, out_valid is 0, in_ready and ack_ready are 1, and counter k's mapping register holds k.
- R2: An accepted ingress message whose index i satisfies IN_BASE <= i < IN_BASE+NUM_CTR adds one to counter i-IN_BASE. A message with any other index is accepted and changes no counter and emits no event.
- R3: A counter at its maximum (2^CNT_W-1) that receives a message stays at its maximum and emits no event.
- R4: When a counter moves from 0 to a non-zero value, one egress event is emitted with out_up=1 and out_idx equal to that counter's mapping register.
- R5: An accepted acknowledge subtracts ack_amt from counter ack_ctr, and the result is clamped at 0. A move from non-zero to 0 emits one egress event with out_up=0 and out_idx equal to the mapping register.
- R6: A counter change that does not cross zero (non-zero to non-zero, or an acknowledge on a counter that is already 0) emits no event.
- R7: An ingress message and an acknowledge that hit the same counter in one cycle are applied together as one net change. At most one event follows, decided by the old and net values.
- R8: A write of map_idx with map_we high sets counter map_ctr's mapping register. Events generated in later cycles carry the new index.
- R9: Egress events leave in generation order. Events produced in one cycle leave ingress-caused first, then acknowledge-caused, and the head holds stable while out_ready is low.
- R10: in_ready is low while fewer than two queue entries are free, and ack_ready is low while the queue is full. No event is lost, and an ingress message or acknowledge that is offered while not ready changes no counter.
- R11: An egress event whose index is fed back on the ingress lane is counted like any other message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Ingress message valid |
| in_ready | output | 1 | Ingress message accepted when high with in_valid |
| in_idx | input | IDX_W | Global index of the ingress message |
| ack_valid | input | 1 | Acknowledge request valid |
| ack_ready | output | 1 | Acknowledge accepted when high with ack_valid |
| ack_ctr | input | SEL_W | Counter to decrement |
| ack_amt | input | CNT_W | Amount to subtract |
| map_we | input | 1 | Mapping register write strobe |
| map_ctr | input | SEL_W | Counter whose mapping register is written |
| map_idx | input | IDX_W | Egress index to store |
| rd_ctr | input | SEL_W | Counter selected for readback |
| rd_count | output | CNT_W | Current value of the selected counter |
| out_valid | output | 1 | Egress event valid |
| out_ready | input | 1 | Egress lane ready |
| out_idx | output | IDX_W | Egress event global index |
| out_up | output | 1 | 1 = count-up event, 0 = count-down event |

## Verification
The bench goes after the boundaries of the zero crossing: counts of 0 and 1, a clamped over-subtraction, saturation at the maximum, and an ingress message and an acknowledge that hit the same counter in one cycle. A design that treated these as two separate updates would emit a spurious pair of events or miss the net fall. The bench also fills the queue while the egress lane is stalled, which shows whether the ready thresholds drop events or let a refused message change a counter. A queue that stores a two-event cycle in the wrong order shows up there too. Further tests rewrite a mapping register and feed an emitted index back into the ingress lane, which catches a stale index and a loop that does not count.

// File: rtl/evc_pkg.sv
package evc_pkg;

    // Zero-crossing classification of a counter update
    typedef enum logic [1:0] {
        TR_NONE = 2'd0,
        TR_RISE = 2'd1,
        TR_FALL = 2'd2
    } trans_e;

    function automatic trans_e classify(input logic was_zero, input logic is_zero);
        if (was_zero && !is_zero) begin
            return TR_RISE;
        end
        if (!was_zero && is_zero) begin
            return TR_FALL;
        end
        return TR_NONE;
    endfunction

endpackage

// File: rtl/evc_counter_bank.sv
module evc_counter_bank
    import evc_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int CNT_W   = 4,
    parameter int IDX_W   = 8,
    localparam int SEL_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_fire,
    input  logic [SEL_W-1:0] inc_sel,
    input  logic             dec_fire,
    input  logic [SEL_W-1:0] dec_sel,
    input  logic [CNT_W-1:0] dec_amt,
    input  logic             map_we,
    input  logic [SEL_W-1:0] map_sel,
    input  logic [IDX_W-1:0] map_val,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [CNT_W-1:0] rd_val,
    output logic             ev_a_vld,
    output logic             ev_a_up,
    output logic [IDX_W-1:0] ev_a_idx,
    output logic             ev_b_vld,
    output logic             ev_b_up,
    output logic [IDX_W-1:0] ev_b_idx
);

    typedef struct packed {
        logic [NUM_CTR-1:0][CNT_W-1:0] cnt;
        logic [NUM_CTR-1:0][IDX_W-1:0] map;
    } bank_state_t;

    bank_state_t st_q, st_d;

    logic [CNT_W-1:0] nxt_cnt [NUM_CTR];
    trans_e           tr_a, tr_b;
    logic             same_ctr;

    // Per-counter net update: old + inc - dec, clamped to [0, max]
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        logic             hit_inc;
        logic [CNT_W-1:0] dec_g;
        logic [CNT_W:0]   up_sum;
        logic [CNT_W:0]   diff;

        assign hit_inc = inc_fire && (inc_sel == SEL_W'(g));
        assign dec_g   = (dec_fire && (dec_sel == SEL_W'(g))) ? dec_amt : '0;
        assign up_sum  = {1'b0, st_q.cnt[g]} + {{CNT_W{1'b0}}, hit_inc};
        assign diff    = up_sum - {1'b0, dec_g};

        always_comb begin
            if (up_sum < {1'b0, dec_g}) begin
                nxt_cnt[g] = '0;
            end else if (diff[CNT_W]) begin
                nxt_cnt[g] = '1;
            end else begin
                nxt_cnt[g] = diff[CNT_W-1:0];
            end
        end

        // R4: an increment alone on a zero counter leaves it at one
        p_rise_to_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_inc && (dec_g == '0) && (st_q.cnt[g] == '0)) |=> (st_q.cnt[g] == CNT_W'(1)));

        // R3: a saturated counter without a decrement stays saturated
        p_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ((st_q.cnt[g] == '1) && (dec_g == '0)) |=> (st_q.cnt[g] == '1));

        // R5: a decrement at least as large as the count clears it
        p_clamp_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit_inc && (dec_g != '0) && (dec_g >= st_q.cnt[g])) |=> (st_q.cnt[g] == '0));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CTR; i++) begin
            st_d.cnt[i] = nxt_cnt[i];
        end
        if (map_we) begin
            st_d.map[map_sel] = map_val;
        end

        same_ctr = inc_fire && dec_fire && (inc_sel == dec_sel);

        tr_a     = classify(st_q.cnt[inc_sel] == '0, nxt_cnt[inc_sel] == '0);
        ev_a_vld = inc_fire && (tr_a != TR_NONE);
        ev_a_up  = (tr_a == TR_RISE);
        ev_a_idx = st_q.map[inc_sel];

        tr_b     = classify(st_q.cnt[dec_sel] == '0, nxt_cnt[dec_sel] == '0);
        ev_b_vld = dec_fire && !same_ctr && (tr_b != TR_NONE);
        ev_b_up  = (tr_b == TR_RISE);
        ev_b_idx = st_q.map[dec_sel];

        rd_val   = st_q.cnt[rd_sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CTR; i++) begin
                st_q.cnt[i] <= '0;
                st_q.map[i] <= IDX_W'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/evc_egress_fifo.sv
module evc_egress_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 9,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_a,
    input  logic [W-1:0]  data_a,
    input  logic          push_b,
    input  logic [W-1:0]  data_b,
    input  logic          pop,
    output logic          head_vld,
    output logic [W-1:0]  head,
    output logic [CW-1:0] free_cnt
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr;
        logic [PW-1:0]           rd;
        logic [CW-1:0]           count;
    } fifo_state_t;

    fifo_state_t s_q, s_d;

    logic [1:0]   n_push;
    logic         do_pop;
    logic [W-1:0] first;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p, input logic [1:0] k);
        logic [PW+1:0] t;
        t = {2'b00, p} + {{PW{1'b0}}, k};
        if (t >= (PW+2)'(DEPTH)) begin
            t = t - (PW+2)'(DEPTH);
        end
        return t[PW-1:0];
    endfunction

    always_comb begin
        s_d    = s_q;
        n_push = {1'b0, push_a} + {1'b0, push_b};
        do_pop = pop && (s_q.count != '0);
        first  = push_a ? data_a : data_b;

        if (push_a || push_b) begin
            s_d.mem[s_q.wr] = first;
        end
        if (push_a && push_b) begin
            s_d.mem[step_ptr(s_q.wr, 2'd1)] = data_b;
        end
        s_d.wr    = step_ptr(s_q.wr, n_push);
        s_d.rd    = step_ptr(s_q.rd, {1'b0, do_pop});
        s_d.count = s_q.count + CW'(n_push) - CW'(do_pop);

        head_vld = (s_q.count != '0);
        head     = s_q.mem[s_q.rd];
        free_cnt = CW'(DEPTH) - s_q.count;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R10: no push reaches a full queue
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.count == CW'(DEPTH)) |-> !(push_a || push_b));

    // R10: occupancy never exceeds the depth
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.count <= CW'(DEPTH)));

    // R9: a stalled head stays put
    p_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (head_vld && !pop) |=> (head_vld && $stable(head)));

endmodule

// File: rtl/evt_msg_counter.sv
module evt_msg_counter #(
    parameter int NUM_CTR    = 8,
    parameter int CNT_W      = 4,
    parameter int IDX_W      = 8,
    parameter int IN_BASE    = 16,
    parameter int FIFO_DEPTH = 4,
    localparam int SEL_W     = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IDX_W-1:0] in_idx,
    input  logic             ack_valid,
    output logic             ack_ready,
    input  logic [SEL_W-1:0] ack_ctr,
    input  logic [CNT_W-1:0] ack_amt,
    input  logic             map_we,
    input  logic [SEL_W-1:0] map_ctr,
    input  logic [IDX_W-1:0] map_idx,
    input  logic [SEL_W-1:0] rd_ctr,
    output logic [CNT_W-1:0] rd_count,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [IDX_W-1:0] out_idx,
    output logic             out_up
);

    localparam int RW  = IDX_W + 1;
    localparam int EW  = IDX_W + 1;
    localparam int FCW = $clog2(FIFO_DEPTH + 1);

    logic [RW-1:0]    rel;
    logic             in_range;
    logic             ack_ok, map_ok, rd_ok;
    logic             inc_fire, dec_fire;
    logic [CNT_W-1:0] bank_rd;
    logic             ev_a_vld, ev_a_up, ev_b_vld, ev_b_up;
    logic [IDX_W-1:0] ev_a_idx, ev_b_idx;
    logic [EW-1:0]    head;
    logic             head_vld;
    logic [FCW-1:0]   free_cnt;

    // Ingress window decode
    assign rel      = {1'b0, in_idx} - RW'(IN_BASE);
    assign in_range = !rel[RW-1] && (rel < RW'(NUM_CTR));

    // Selector range guards: only needed when the array is not a power of two
    if (NUM_CTR == (1 << SEL_W)) begin : g_full_sel
        assign ack_ok = 1'b1;
        assign map_ok = 1'b1;
        assign rd_ok  = 1'b1;
    end else begin : g_part_sel
        assign ack_ok = (ack_ctr < SEL_W'(NUM_CTR));
        assign map_ok = (map_ctr < SEL_W'(NUM_CTR));
        assign rd_ok  = (rd_ctr  < SEL_W'(NUM_CTR));
    end

    assign in_ready  = (free_cnt >= FCW'(2));
    assign ack_ready = (free_cnt != '0);
    assign inc_fire  = in_valid && in_ready && in_range;
    assign dec_fire  = ack_valid && ack_ready && ack_ok;
    assign rd_count  = rd_ok ? bank_rd : '0;

    evc_counter_bank #(
        .NUM_CTR (NUM_CTR),
        .CNT_W   (CNT_W),
        .IDX_W   (IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_fire (inc_fire),
        .inc_sel  (rel[SEL_W-1:0]),
        .dec_fire (dec_fire),
        .dec_sel  (ack_ctr),
        .dec_amt  (ack_amt),
        .map_we   (map_we && map_ok),
        .map_sel  (map_ctr),
        .map_val  (map_idx),
        .rd_sel   (rd_ctr),
        .rd_val   (bank_rd),
        .ev_a_vld (ev_a_vld),
        .ev_a_up  (ev_a_up),
        .ev_a_idx (ev_a_idx),
        .ev_b_vld (ev_b_vld),
        .ev_b_up  (ev_b_up),
        .ev_b_idx (ev_b_idx)
    );

    evc_egress_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (EW)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_a   (ev_a_vld),
        .data_a   ({ev_a_up, ev_a_idx}),
        .push_b   (ev_b_vld),
        .data_b   ({ev_b_up, ev_b_idx}),
        .pop      (out_ready),
        .head_vld (head_vld),
        .head     (head),
        .free_cnt (free_cnt)
    );

    assign out_valid = head_vld;
    assign out_up    = head[EW-1];
    assign out_idx   = head[IDX_W-1:0];

    // R10: a refused ingress message does not touch the counter it names
    p_refused_ingress_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready && !ack_valid && in_range && (rd_ctr == rel[SEL_W-1:0]))
        |=> (rd_count == $past(rd_count)));

endmodule

// File: tb/sim_evt_msg_counter.sv
`timescale 1ns/1ps
module sim_evt_msg_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_idx = '0;
    logic       ack_valid = 1'b0;
    logic       ack_ready;
    logic [2:0] ack_ctr = '0;
    logic [3:0] ack_amt = '0;
    logic       map_we = 1'b0;
    logic [2:0] map_ctr = '0;
    logic [7:0] map_idx = '0;
    logic [2:0] rd_ctr = '0;
    logic [3:0] rd_count;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_idx;
    logic       out_up;

    always #2 clk = ~clk;   // 250 MHz

    evt_msg_counter u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx),
        .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_ctr(ack_ctr), .ack_amt(ack_amt),
        .map_we(map_we), .map_ctr(map_ctr), .map_idx(map_idx),
        .rd_ctr(rd_ctr), .rd_count(rd_count),
        .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx), .out_up(out_up)
    );

    int n_checks = 0;
    int n_fail = 0;

    // Egress monitor: log every completed handshake
    int         ev_total = 0;
    logic [7:0] ev_idx_log [64];
    logic       ev_up_log  [64];
    int         ev_base = 0;

    always @(posedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            ev_idx_log[ev_total % 64] <= out_idx;
            ev_up_log[ev_total % 64]  <= out_up;
            ev_total <= ev_total + 1;
        end
    end

    function automatic int ev_seen();
        return ev_total - ev_base;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic chk_event(input string req, input int k, input int up, input int idx);
        chk_eq({req, " event up"}, int'(ev_up_log[(ev_base + k) % 64]), up);
        chk_eq({req, " event idx"}, int'(ev_idx_log[(ev_base + k) % 64]), idx);
    endtask

    task automatic read_ctr(input int c, output int v);
        rd_ctr = 3'(c);
        #0.5;
        v = int'(rd_count);
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    // Ingress message: held until accepted; called at a negedge
    task automatic send_in(input int idx);
        in_valid = 1'b1;
        in_idx = 8'(idx);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_ack(input int c, input int amt);
        ack_valid = 1'b1;
        ack_ctr = 3'(c);
        ack_amt = 4'(amt);
        while (!ack_ready) @(negedge clk);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic send_both(input int idx, input int c, input int amt);
        in_valid = 1'b1;
        in_idx = 8'(idx);
        ack_valid = 1'b1;
        ack_ctr = 3'(c);
        ack_amt = 4'(amt);
        @(negedge clk);
        in_valid = 1'b0;
        ack_valid = 1'b0;
    endtask

    // Vector table: one operation, then the counter and event it must produce
    typedef struct packed {
        logic       is_ack;
        logic [7:0] idx;
        logic [2:0] sel;
        logic [3:0] amt;
        logic [2:0] chk;
        logic [3:0] exp_cnt;
        logic       exp_ev;
        logic       exp_up;
        logic [7:0] exp_oidx;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd18, 3'd0, 4'd0,  3'd2, 4'd1, 1'b1, 1'b1, 8'd2}, // R4 rise on counter 2
        '{1'b0, 8'd18, 3'd0, 4'd0,  3'd2, 4'd2, 1'b0, 1'b0, 8'd0}, // R6 no event 1->2
        '{1'b1, 8'd0,  3'd2, 4'd1,  3'd2, 4'd1, 1'b0, 1'b0, 8'd0}, // R6 no event 2->1
        '{1'b1, 8'd0,  3'd2, 4'd5,  3'd2, 4'd0, 1'b1, 1'b0, 8'd2}, // R5 clamp and fall
        '{1'b1, 8'd0,  3'd2, 4'd1,  3'd2, 4'd0, 1'b0, 1'b0, 8'd0}, // R5 ack on zero stays zero
        '{1'b0, 8'd21, 3'd0, 4'd0,  3'd5, 4'd1, 1'b1, 1'b1, 8'd5}, // R4 rise on counter 5
        '{1'b0, 8'd3,  3'd0, 4'd0,  3'd3, 4'd0, 1'b0, 1'b0, 8'd0}, // R2 index below window
        '{1'b0, 8'd24, 3'd0, 4'd0,  3'd0, 4'd0, 1'b0, 1'b0, 8'd0}, // R2 index above window
        '{1'b1, 8'd0,  3'd5, 4'd15, 3'd5, 4'd0, 1'b1, 1'b0, 8'd5}, // R5 fall on counter 5
        '{1'b1, 8'd0,  3'd4, 4'd0,  3'd4, 4'd0, 1'b0, 1'b0, 8'd0}  // R6 zero-amount ack
    };

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_eq("R1 out_valid", int'(out_valid), 0);
        chk_eq("R1 in_ready", int'(in_ready), 1);
        chk_eq("R1 ack_ready", int'(ack_ready), 1);
        for (int c = 0; c < 8; c++) begin
            read_ctr(c, v);
            chk_eq("R1 counter zero", v, 0);
        end

        // Table walk
        for (int k = 0; k < NV; k++) begin
            ev_base = ev_total;
            @(negedge clk);
            if (VECS[k].is_ack) begin
                send_ack(int'(VECS[k].sel), int'(VECS[k].amt));
            end else begin
                send_in(int'(VECS[k].idx));
            end
            settle();
            read_ctr(int'(VECS[k].chk), v);
            chk_eq($sformatf("R2/R4/R5/R6 vector %0d count", k), v, int'(VECS[k].exp_cnt));
            chk_eq($sformatf("R4/R5/R6 vector %0d events", k), ev_seen(), int'(VECS[k].exp_ev));
            if (VECS[k].exp_ev && ev_seen() == 1) begin
                chk_event($sformatf("R1/R4/R5 vector %0d", k), 0,
                          int'(VECS[k].exp_up), int'(VECS[k].exp_oidx));
            end
        end

        // R3 saturation on counter 7
        ev_base = ev_total;
        @(negedge clk);
        in_valid = 1'b1;
        in_idx = 8'd23;
        repeat (20) @(negedge clk);
        in_valid = 1'b0;
        settle();
        read_ctr(7, v);
        chk_eq("R3 saturated value", v, 15);
        chk_eq("R3 single rise while saturating", ev_seen(), 1);
        chk_event("R3 rise", 0, 1, 7);
        ev_base = ev_total;
        send_ack(7, 1);
        settle();
        read_ctr(7, v);
        chk_eq("R6 saturated minus one", v, 14);
        chk_eq("R6 no event 15->14", ev_seen(), 0);

        // R7 same-counter increment and acknowledge (counter 4)
        ev_base = ev_total;
        send_both(20, 4, 1);
        settle();
        read_ctr(4, v);
        chk_eq("R7 net zero from zero", v, 0);
        chk_eq("R7 no event on net zero", ev_seen(), 0);
        send_in(20);
        settle();
        ev_base = ev_total;
        send_both(20, 4, 1);
        settle();
        read_ctr(4, v);
        chk_eq("R7 net unchanged at one", v, 1);
        chk_eq("R7 no event when net unchanged", ev_seen(), 0);
        send_both(20, 4, 2);
        settle();
        read_ctr(4, v);
        chk_eq("R7 net fall to zero", v, 0);
        chk_eq("R7 exactly one event", ev_seen(), 1);
        chk_event("R7 fall", 0, 0, 4);

        // R8 mapping rewrite on counter 6
        map_we = 1'b1;
        map_ctr = 3'd6;
        map_idx = 8'h40;
        @(negedge clk);
        map_we = 1'b0;
        ev_base = ev_total;
        send_in(22);
        settle();
        chk_eq("R8 event count", ev_seen(), 1);
        chk_event("R8 remapped", 0, 1, 8'h40);

        // R9/R10 stall: counter 3 to one first
        send_in(19);
        settle();
        ev_base = ev_total;
        out_ready = 1'b0;
        send_both(17, 3, 1);                  // rise on 1, fall on 3
        chk_eq("R10 in_ready with two free", int'(in_ready), 1);
        send_in(16);                          // rise on 0
        chk_eq("R10 in_ready low with one free", int'(in_ready), 0);
        chk_eq("R10 ack_ready with one free", int'(ack_ready), 1);
        send_ack(1, 1);                       // fall on 1
        chk_eq("R10 ack_ready low when full", int'(ack_ready), 0);
        ack_valid = 1'b1;
        ack_ctr = 3'd0;
        ack_amt = 4'd1;
        in_valid = 1'b1;
        in_idx = 8'd18;
        repeat (3) @(negedge clk);
        ack_valid = 1'b0;
        read_ctr(0, v);
        chk_eq("R10 refused ack leaves counter", v, 1);
        read_ctr(2, v);
        chk_eq("R10 refused ingress leaves counter", v, 0);
        chk_eq("R9 head waits", int'(out_valid), 1);
        chk_eq("R9 nothing popped while stalled", ev_seen(), 0);
        out_ready = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk_eq("R10 no event lost", ev_seen(), 5);
        chk_event("R9 order 0", 0, 1, 1);
        chk_event("R9 order 1", 1, 0, 3);
        chk_event("R9 order 2", 2, 1, 0);
        chk_event("R9 order 3", 3, 0, 1);
        chk_event("R9 order 4", 4, 1, 2);
        read_ctr(2, v);
        chk_eq("R10 ingress taken after drain", v, 1);

        // R11 loopback: counter 0 maps into the window at counter 3
        map_we = 1'b1;
        map_ctr = 3'd0;
        map_idx = 8'd19;
        @(negedge clk);
        map_we = 1'b0;
        ev_base = ev_total;
        send_ack(0, 1);
        settle();
        chk_eq("R11 emitted event", ev_seen(), 1);
        chk_event("R11 fall mapped", 0, 0, 19);
        v = int'(ev_idx_log[ev_base % 64]);
        ev_base = ev_total;
        send_in(v);
        settle();
        read_ctr(3, v);
        chk_eq("R11 looped event counted", v, 1);
        chk_eq("R11 looped rise count", ev_seen(), 1);
        chk_event("R11 looped rise", 0, 1, 3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule